// File: doc/BRIEF.md
# Delta-Correlating Address Prefetcher

This block predicts which data address a second-level cache will miss on next. Every demand miss, and every first use of a line that an earlier prefetch brought in, is presented as one trigger carrying the low bits of the instruction address and the full data address. The block keeps one small record per instruction slot. Each record holds a tag, the low half of the last data address seen there, a compressed history of recent address deltas and a two-bit confidence counter. A second, shared table maps each compressed history to the delta that last followed it.

When a trigger finds its own record and the confidence is high enough, the block adds the delta stored for the updated history to the trigger address and issues that address one cycle later. A chaining engine then keeps walking the history, one extra address per cycle, until the requested degree is used up. Before each address is issued, it is offered on a combinational lookup port. An external duplicate filter can veto it there, so addresses already in flight are not sent again.

Top module: `dcp_prefetcher`

## Requirements
- R1: The record slot is `trig_pc[IDX_W-1:0]` and the tag is the 16 bits `trig_pc[IDX_W+15:IDX_W]`. A trigger whose slot is empty or holds another tag rewrites the slot: tag stored, history 0, confidence 0, last address = `trig_addr[15:0]`. Such a trigger issues nothing and ends any running chain.
- R2: On a tag hit, the actual delta is `trig_addr[15:0]` minus the stored last address, modulo 2^16. If it equals the delta table entry at the stored history, the confidence increments and saturates at 3. Otherwise it decrements and saturates at 0.
- R3: The new history is formed as follows. The 16-bit delta is zero-padded and cut into HIST_W-bit pieces, which are XORed together. That result is XORed with the low HIST_W bits of the old history shifted left by 5.
- R4: On a tag hit, the delta table entry at the old history receives the actual delta. A read of that same entry in the same cycle returns the new delta.
- R5: On a tag hit, a prediction is made only when the updated confidence is 2 or more and `degree` is nonzero. The predicted address is `trig_addr` plus the sign-extended delta stored at the new history. It appears on `pf_addr` with `pf_valid` high in the cycle after the trigger.
- R6: After a prediction from a trigger, the chain holds degree-1 further steps. While no trigger arrives, and both the remaining count and the chain history are nonzero, each cycle does one step. The step rehashes the history with the delta between the chain's last two addresses, predicts the next address from the table, and decrements the count.
- R7: A predicted address that is zero or equals its base address (the trigger address, or the chain's current address) is not issued. The chain still advances.
- R8: Every candidate is shown on `filt_addr` with `filt_req` high in the same cycle. If `filt_hit` is high in that cycle, the candidate is not issued.
- R9: A trigger has priority over the chain in the same cycle. A trigger that predicts reloads the chain from its own result.
- R10: After reset, `pf_valid` is low, every record slot is empty, and every delta table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Demand miss or first-use trigger this cycle |
| trig_pc | input | IDX_W+16 | Low bits of the triggering instruction address |
| trig_addr | input | ADDR_W | Data address of the trigger |
| degree | input | DEG_W | Number of predictions per trigger, 0 disables issue |
| filt_req | output | 1 | A candidate address is offered for filtering |
| filt_addr | output | ADDR_W | Candidate address |
| filt_hit | input | 1 | Candidate already outstanding, drop it |
| pf_valid | output | 1 | Prefetch address issued |
| pf_addr | output | ADDR_W | Issued prefetch address |

## Verification
The assertions assume that `filt_hit` is a same-cycle answer to `filt_addr`. They also assume that `degree` and the trigger fields are stable and known whenever `trig_valid` is high. The bench derives `filt_hit` combinationally from `filt_addr` against one blocked address. It changes every input only on the falling edge, so both assumptions hold. The addresses used stay away from zero and from the top of the address space. This keeps the nonzero-issue check meaningful and keeps sign-extended additions from wrapping.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    localparam int TAG_W   = 16;
    localparam int LOW_W   = 16;
    localparam int CONF_W  = 2;
    localparam int HSHIFT  = 5;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LOW_W-1:0]  low_t;
    typedef logic [CONF_W-1:0] conf_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        low_t  last;
        conf_t conf;
    } rec_t;

    function automatic conf_t conf_step(input conf_t c, input logic agree);
        conf_t r;
        if (agree) r = (c == conf_t'(3)) ? c : c + conf_t'(1);
        else       r = (c == conf_t'(0)) ? c : c - conf_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/dcp_hash.sv
module dcp_hash #(
    parameter int HIST_W = 6,
    parameter int DELTA_W = 16,
    parameter int SHIFT = 5
) (
    input  logic [HIST_W-1:0]  hist_i,
    input  logic [DELTA_W-1:0] delta_i,
    output logic [HIST_W-1:0]  hist_o
);
    localparam int PIECES = (DELTA_W + HIST_W - 1) / HIST_W;
    localparam int PAD_W  = PIECES * HIST_W;
    localparam int EXT_W  = HIST_W + SHIFT;

    logic [PAD_W-1:0]  padded;
    logic [EXT_W-1:0]  moved;
    logic [HIST_W-1:0] folded;

    always_comb begin
        padded = PAD_W'(delta_i);
        folded = '0;
        for (int i = 0; i < PIECES; i++) begin
            folded = folded ^ padded[i*HIST_W +: HIST_W];
        end
        moved  = EXT_W'(hist_i) << SHIFT;
        hist_o = moved[HIST_W-1:0] ^ folded;
    end
endmodule

// File: rtl/dcp_rec_table.sv
module dcp_rec_table
    import dcp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output rec_t              rd_rec,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  rec_t              wr_rec,
    input  logic [HIST_W-1:0] wr_hist
);
    localparam int SLOTS = 1 << IDX_W;

    rec_t              rec_q  [SLOTS];
    logic [HIST_W-1:0] hist_q [SLOTS];

    assign rd_rec  = rec_q[rd_idx];
    assign rd_hist = hist_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                rec_q[i]  <= '0;
                hist_q[i] <= '0;
            end
        end else if (wr_en) begin
            rec_q[wr_idx]  <= wr_rec;
            hist_q[wr_idx] <= wr_hist;
        end
    end
endmodule

// File: rtl/dcp_delta_table.sv
module dcp_delta_table #(
    parameter int HIST_W = 6,
    parameter int DELTA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HIST_W-1:0]  rd_a_idx,
    output logic [DELTA_W-1:0] rd_a_val,
    input  logic [HIST_W-1:0]  rd_b_idx,
    output logic [DELTA_W-1:0] rd_b_val,
    input  logic               wr_en,
    input  logic [HIST_W-1:0]  wr_idx,
    input  logic [DELTA_W-1:0] wr_val
);
    localparam int ROWS = 1 << HIST_W;

    logic [DELTA_W-1:0] mem_q [ROWS];

    assign rd_a_val = mem_q[rd_a_idx];
    assign rd_b_val = mem_q[rd_b_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/dcp_prefetcher.sv
module dcp_prefetcher
    import dcp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 6,
    parameter int DEG_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_valid,
    input  logic [IDX_W+TAG_W-1:0]  trig_pc,
    input  logic [ADDR_W-1:0]       trig_addr,
    input  logic [DEG_W-1:0]        degree,
    output logic                    filt_req,
    output logic [ADDR_W-1:0]       filt_addr,
    input  logic                    filt_hit,
    output logic                    pf_valid,
    output logic [ADDR_W-1:0]       pf_addr
);
    localparam int EXT_W = ADDR_W - LOW_W;

    typedef struct packed {
        logic              pf_valid;
        logic [ADDR_W-1:0] pf_addr;
        logic [HIST_W-1:0] ch_hist;
        low_t              ch_last;
        logic [ADDR_W-1:0] ch_addr;
        logic [DEG_W-1:0]  ch_deg;
    } state_t;

    state_t state_d, state_q;

    // table interfaces
    logic [IDX_W-1:0]  slot;
    tag_t              tag_in;
    rec_t              rec_rd, rec_wr;
    logic [HIST_W-1:0] hist_rd, hist_wr;
    logic              rec_we;
    low_t              dt_old_val, dt_new_raw;
    logic [HIST_W-1:0] dt_b_idx;
    logic              dt_we;

    // datapath
    logic              tag_hit;
    low_t              act_delta, ch_delta, use_delta;
    conf_t             conf_nx;
    logic [HIST_W-1:0] hist_trig, hist_chain;
    logic [ADDR_W-1:0] base, pred;
    logic              trig_pred, chain_go, cand, issue;

    assign slot   = trig_pc[IDX_W-1:0];
    assign tag_in = trig_pc[IDX_W +: TAG_W];

    dcp_rec_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(slot), .rd_rec(rec_rd), .rd_hist(hist_rd),
        .wr_en(rec_we), .wr_idx(slot), .wr_rec(rec_wr), .wr_hist(hist_wr)
    );

    dcp_delta_table #(.HIST_W(HIST_W), .DELTA_W(LOW_W)) u_dt (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(hist_rd), .rd_a_val(dt_old_val),
        .rd_b_idx(dt_b_idx), .rd_b_val(dt_new_raw),
        .wr_en(dt_we), .wr_idx(hist_rd), .wr_val(act_delta)
    );

    dcp_hash #(.HIST_W(HIST_W), .DELTA_W(LOW_W), .SHIFT(HSHIFT)) u_hash_trig (
        .hist_i(hist_rd), .delta_i(act_delta), .hist_o(hist_trig)
    );

    dcp_hash #(.HIST_W(HIST_W), .DELTA_W(LOW_W), .SHIFT(HSHIFT)) u_hash_chain (
        .hist_i(state_q.ch_hist), .delta_i(ch_delta), .hist_o(hist_chain)
    );

    always_comb begin
        state_d = state_q;

        tag_hit   = rec_rd.valid && (rec_rd.tag == tag_in);
        act_delta = trig_addr[LOW_W-1:0] - rec_rd.last;
        conf_nx   = conf_step(rec_rd.conf, act_delta == dt_old_val);
        ch_delta  = state_q.ch_addr[LOW_W-1:0] - state_q.ch_last;

        dt_b_idx  = trig_valid ? hist_trig : hist_chain;
        // same-cycle write to the entry being read returns the new delta
        use_delta = (trig_valid && hist_trig == hist_rd) ? act_delta : dt_new_raw;
        base      = trig_valid ? trig_addr : state_q.ch_addr;
        pred      = base + {{EXT_W{use_delta[LOW_W-1]}}, use_delta};

        trig_pred = trig_valid && tag_hit && conf_nx[1] && (degree != '0);
        chain_go  = !trig_valid && (state_q.ch_deg != '0) && (state_q.ch_hist != '0);
        cand      = trig_pred || chain_go;
        issue     = cand && (pred != '0) && (pred != base) && !filt_hit;

        filt_req  = cand;
        filt_addr = pred;

        // history record and delta table updates
        rec_we  = trig_valid;
        dt_we   = trig_valid && tag_hit;
        rec_wr.valid = 1'b1;
        rec_wr.tag   = tag_in;
        rec_wr.last  = trig_addr[LOW_W-1:0];
        rec_wr.conf  = tag_hit ? conf_nx : '0;
        hist_wr      = tag_hit ? hist_trig : '0;

        // output register
        state_d.pf_valid = issue;
        if (issue) state_d.pf_addr = pred;

        // chaining engine
        if (trig_valid) begin
            if (trig_pred) begin
                state_d.ch_hist = hist_trig;
                state_d.ch_last = trig_addr[LOW_W-1:0];
                state_d.ch_addr = pred;
                state_d.ch_deg  = degree - DEG_W'(1);
            end else begin
                state_d.ch_deg  = '0;
            end
        end else if (chain_go) begin
            state_d.ch_hist = hist_chain;
            state_d.ch_last = state_q.ch_addr[LOW_W-1:0];
            state_d.ch_addr = pred;
            state_d.ch_deg  = state_q.ch_deg - DEG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pf_valid = state_q.pf_valid;
    assign pf_addr  = state_q.pf_addr;
endmodule

// File: rtl/dcp_prefetcher_chk.sv
module dcp_prefetcher_chk #(
    parameter int ADDR_W = 32,
    parameter int DEG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_valid,
    input logic [ADDR_W-1:0] trig_addr,
    input logic [DEG_W-1:0]  degree,
    input logic              filt_hit,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr
);
    AST_PF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr != '0));                                   // R7

    AST_PF_NOT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> !(pf_valid && pf_addr == $past(trig_addr)));      // R7

    AST_FILTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        filt_hit |=> !pf_valid);                                         // R8

    AST_DEG0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && degree == '0) |=> !pf_valid);                     // R5

    AST_PF_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pf_valid));                                          // R10
endmodule

bind dcp_prefetcher dcp_prefetcher_chk #(.ADDR_W(ADDR_W), .DEG_W(DEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_addr(trig_addr),
    .degree(degree), .filt_hit(filt_hit), .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/dcp_prefetcher_tb.sv
module dcp_prefetcher_tb;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
    localparam int HIST_W = 6;
    localparam int DEG_W  = 4;
    localparam int PC_W   = IDX_W + 16;

    localparam logic [PC_W-1:0] PC_A = 20'h10010; // slot 0, tag 0x1001
    localparam logic [PC_W-1:0] PC_X = 20'h20010; // slot 0, tag 0x2001
    localparam logic [PC_W-1:0] PC_B = 20'h30011; // slot 1
    localparam logic [PC_W-1:0] PC_C = 20'h40012; // slot 2

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_valid = 1'b0;
    logic [PC_W-1:0]   trig_pc = '0;
    logic [ADDR_W-1:0] trig_addr = '0;
    logic [DEG_W-1:0]  degree = '0;
    logic              filt_req;
    logic [ADDR_W-1:0] filt_addr;
    logic              filt_hit;
    logic              pf_valid;
    logic [ADDR_W-1:0] pf_addr;

    logic              blk_en = 1'b0;
    logic [ADDR_W-1:0] blk_addr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign filt_hit = blk_en && filt_req && (filt_addr == blk_addr);

    dcp_prefetcher #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .DEG_W(DEG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_pc(trig_pc),
        .trig_addr(trig_addr), .degree(degree), .filt_req(filt_req),
        .filt_addr(filt_addr), .filt_hit(filt_hit), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    task automatic chk(input logic ev, input logic [ADDR_W-1:0] ea, input string req);
        checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            errors++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%h, expected pf_valid=%0b pf_addr=%h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    task automatic step_trig(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                             input logic [DEG_W-1:0] d, input logic ev,
                             input logic [ADDR_W-1:0] ea, input string req);
        @(negedge clk);
        trig_valid = 1'b1; trig_pc = pc; trig_addr = a; degree = d;
        @(posedge clk); #1;
        chk(ev, ea, req);
    endtask

    task automatic step_idle(input logic ev, input logic [ADDR_W-1:0] ea, input string req);
        @(negedge clk);
        trig_valid = 1'b0;
        @(posedge clk); #1;
        chk(ev, ea, req);
    endtask

    task automatic t_reset();
        chk(1'b0, '0, "R10 reset");
        step_idle(1'b0, '0, "R10 idle after reset");
    endtask

    // stride 0x40: history settles on 33, confidence reaches 2 on the sixth trigger
    task automatic t_train();
        step_trig(PC_A, 32'h1000, 4'd3, 1'b0, '0, "R1 first use of slot");
        step_trig(PC_A, 32'h1040, 4'd3, 1'b0, '0, "R2 delta mismatch");
        step_trig(PC_A, 32'h1080, 4'd3, 1'b0, '0, "R3 history 1");
        step_trig(PC_A, 32'h10C0, 4'd3, 1'b0, '0, "R4 history 33 written");
        step_trig(PC_A, 32'h1100, 4'd3, 1'b0, '0, "R2 confidence 1");
        step_trig(PC_A, 32'h1140, 4'd3, 1'b1, 32'h1180, "R5 first prediction");
        step_idle(1'b1, 32'h11C0, "R6 chain step 1");
        step_idle(1'b1, 32'h1200, "R6 chain step 2");
        step_idle(1'b0, '0, "R6 chain exhausted");
    endtask

    task automatic t_degree_zero();
        step_trig(PC_A, 32'h1180, 4'd0, 1'b0, '0, "R5 degree zero");
        step_idle(1'b0, '0, "R5 no chain at degree zero");
    endtask

    task automatic t_filter();
        blk_en = 1'b1; blk_addr = 32'h1240;
        step_trig(PC_A, 32'h11C0, 4'd3, 1'b1, 32'h1200, "R8 unblocked");
        step_idle(1'b0, '0, "R8 blocked candidate");
        step_idle(1'b1, 32'h1280, "R8 chain advances past block");
        step_idle(1'b0, '0, "R6 chain done");
        blk_en = 1'b0;
    endtask

    task automatic t_priority();
        step_trig(PC_A, 32'h1200, 4'd4, 1'b1, 32'h1240, "R9 first trigger");
        step_trig(PC_A, 32'h1240, 4'd1, 1'b1, 32'h1280, "R9 trigger wins");
        step_idle(1'b0, '0, "R9 chain reloaded with degree 1");
    endtask

    task automatic t_replace();
        step_trig(PC_A, 32'h1280, 4'd4, 1'b1, 32'h12C0, "R5 chain start");
        step_trig(PC_X, 32'h7000, 4'd4, 1'b0, '0, "R1 tag miss no prediction");
        step_idle(1'b0, '0, "R1 chain ended by tag miss");
        step_trig(PC_A, 32'h1300, 4'd4, 1'b0, '0, "R1 slot replaced again");
        step_trig(PC_A, 32'h1340, 4'd4, 1'b0, '0, "R1 confidence cleared");
    endtask

    task automatic t_same_addr();
        step_trig(PC_B, 32'h5000, 4'd2, 1'b0, '0, "R1 slot 1 fill");
        step_trig(PC_B, 32'h5000, 4'd2, 1'b0, '0, "R2 zero delta mismatch");
        step_trig(PC_B, 32'h5000, 4'd2, 1'b0, '0, "R2 confidence 1");
        step_trig(PC_B, 32'h5000, 4'd2, 1'b0, '0, "R7 prediction equals trigger");
        step_idle(1'b0, '0, "R6 zero history stops chain");
    endtask

    task automatic t_descend();
        step_trig(PC_C, 32'h9000, 4'd2, 1'b0, '0, "R1 slot 2 fill");
        step_trig(PC_C, 32'h8FC0, 4'd2, 1'b0, '0, "R3 history 48");
        step_trig(PC_C, 32'h8F80, 4'd2, 1'b0, '0, "R4 store negative delta");
        step_trig(PC_C, 32'h8F40, 4'd2, 1'b0, '0, "R2 confidence 1");
        step_trig(PC_C, 32'h8F00, 4'd2, 1'b1, 32'h8EC0, "R5 sign-extended delta");
        step_idle(1'b1, 32'h8E80, "R6 descending chain");
        step_idle(1'b0, '0, "R6 degree 2 used up");
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_train();
        t_degree_zero();
        t_filter();
        t_priority();
        t_replace();
        t_same_addr();
        t_descend();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule